// File: doc/BRIEF.md
# Dual-Channel Serial Wiper Register Interface

This block is the write-only serial front end of a two-channel, 256-position digitally controlled resistor. A host drives three wires: serial data, serial clock and an active-low select. While select is low, every rising edge of the serial clock shifts one data bit into a shift register. When select rises, the last nine bits captured are decoded: the first of those nine picks the channel, and the remaining eight form the new wiper code for that channel.

The serial clock, select and data wires are asynchronous to the system clock. Each goes through a two-flop synchronizer, and edges are detected on the synchronized copies. The two wiper codes are driven out continuously. Each channel also has its own strobe, which is high for one system clock in the cycle where that channel's register takes its new value.

Top module: `dual_wiper_serial_if`

## Requirements
- R1: After reset both wiper codes equal midscale (128) and both load strobes are low.
- R2: A frame is sent most-significant bit first. Of the nine bits kept, the first is the channel bit and the next eight are the wiper code, D7 first and D0 last. Channel bit 0 updates `wiper_code[0]` and channel bit 1 updates `wiper_code[1]`.
- R3: The wiper registers do not change while bits are being shifted. A register takes its new code only after select rises.
- R4: If a frame holds more than nine clocks, the earlier bits are dropped and only the final nine decide the update.
- R5: A frame with fewer than nine clocks before select rises changes neither register and raises no strobe.
- R6: The channel that is not addressed keeps its code.
- R7: Each update raises exactly one cycle of `load_stb` for the addressed channel only. This happens in the same cycle that the new code appears on that channel's `wiper_code`.
- R8: Serial clock edges while select is high have no effect on the shift register or the bit count.
- R9: Every code from 0 to 255 can be loaded, including both end values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous; data sampled on its rising edge |
| csn | input | 1 | Active-low select, asynchronous; its rising edge commits the frame |
| sdi | input | 1 | Serial data, asynchronous |
| wiper_code | output | 2x8 | Current wiper code per channel, packed [channel][bit] |
| load_stb | output | 2 | One-cycle strobe per channel on each register update |

## Verification
The assertions assume the serial wires change slowly compared with the system clock. Each serial clock level and each select level must last long enough to pass the synchronizers, so no two select rises fall within a few cycles of each other. They also assume data is stable around each serial clock rise. The stimulus holds each serial clock phase for four system clocks and changes data only while the serial clock is low. It also leaves idle gaps of several cycles around every select edge. Under those conditions, a strobe can only follow a select rise by one cycle, and a register can only move together with its strobe.

// File: rtl/wsi_pkg.sv
package wsi_pkg;
  localparam int CODE_W   = 8;
  localparam int NUM_CH   = 2;
  localparam int ADDR_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int WORD_W   = ADDR_W + CODE_W;
  localparam int CNT_W    = $clog2(WORD_W + 1);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  function automatic addr_t word_addr(input word_t w);
    return w[WORD_W-1 -: ADDR_W];
  endfunction

  function automatic code_t word_code(input word_t w);
    return w[CODE_W-1:0];
  endfunction

  function automatic code_t midscale();
    code_t m;
    m = '0;
    m[CODE_W-1] = 1'b1;
    return m;
  endfunction

  function automatic logic frame_complete(input cnt_t c);
    return (int'(c) >= WORD_W);
  endfunction

  function automatic cnt_t count_step(input cnt_t c);
    return frame_complete(c) ? c : cnt_t'(c + 1'b1);
  endfunction
endpackage

// File: rtl/wsi_sync.sv
module wsi_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wsi_shifter.sv
module wsi_shifter
  import wsi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  shift_en,
  input  logic  bit_in,
  input  logic  clr,
  output word_t word,
  output cnt_t  bit_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (clr) begin
      bit_cnt <= '0;
    end else if (shift_en) begin
      word    <= {word[WORD_W-2:0], bit_in};
      bit_cnt <= count_step(bit_cnt);
    end
  end
endmodule

// File: rtl/wsi_wiper_bank.sv
module wsi_wiper_bank
  import wsi_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_en,
  input  word_t                         word,
  output logic [NUM_CH-1:0][CODE_W-1:0] codes,
  output logic [NUM_CH-1:0]             stb
);
  addr_t dest;
  assign dest = word_addr(word);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic hit;
    assign hit = load_en && (int'(dest) == ch);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        codes[ch] <= midscale();
        stb[ch]   <= 1'b0;
      end else begin
        stb[ch] <= hit;
        if (hit) codes[ch] <= word_code(word);
      end
    end
  end
endmodule

// File: rtl/dual_wiper_serial_if.sv
module dual_wiper_serial_if
  import wsi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 sclk,
  input  logic                                 csn,
  input  logic                                 sdi,
  output logic [NUM_CH-1:0][CODE_W-1:0]        wiper_code,
  output logic [NUM_CH-1:0]                    load_stb
);
  logic [1:0] clk_dat_s;
  logic       sclk_s, sdi_s, csn_s;
  logic       sclk_q, csn_q;

  // Named internal events, observed by the checker
  logic  sclk_rise_w;
  logic  cs_rise_w;
  logic  shift_en_w;
  logic  commit_w;
  word_t word_w;
  cnt_t  bit_cnt_w;

  wsi_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_cd (
    .clk(clk), .rst_n(rst_n), .d({sclk, sdi}), .q(clk_dat_s)
  );
  wsi_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(csn), .q(csn_s)
  );

  assign sclk_s = clk_dat_s[1];
  assign sdi_s  = clk_dat_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      csn_q  <= csn_s;
    end
  end

  assign sclk_rise_w = sclk_s & ~sclk_q;
  assign cs_rise_w   = csn_s & ~csn_q;
  assign shift_en_w  = sclk_rise_w & ~csn_s;
  assign commit_w    = cs_rise_w & frame_complete(bit_cnt_w);

  wsi_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en_w), .bit_in(sdi_s),
    .clr(cs_rise_w), .word(word_w), .bit_cnt(bit_cnt_w)
  );

  wsi_wiper_bank u_bank (
    .clk(clk), .rst_n(rst_n), .load_en(commit_w), .word(word_w),
    .codes(wiper_code), .stb(load_stb)
  );
endmodule

// File: rtl/wsi_checker.sv
module wsi_checker
  import wsi_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          csn_s,
  input logic                          cs_rise,
  input cnt_t                          bit_cnt,
  input logic [NUM_CH-1:0][CODE_W-1:0] codes,
  input logic [NUM_CH-1:0]             stb
);
  // R7
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

  // R7
  stb_follows_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb != '0) |-> $past(cs_rise));

  // R5
  short_frame_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !frame_complete(bit_cnt)) |=> (stb == '0));

  // R8
  idle_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && !cs_rise) |=> $stable(bit_cnt));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R3
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stb[ch] |-> $stable(codes[ch]));

    // R7
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb[ch] |=> !stb[ch]);
  end
endmodule

bind dual_wiper_serial_if wsi_checker u_wsi_chk (
  .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .cs_rise(cs_rise_w),
  .bit_cnt(bit_cnt_w), .codes(wiper_code), .stb(load_stb)
);

// File: tb/test_dual_wiper_serial_if.sv
module test_dual_wiper_serial_if;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sclk = 1'b0;
  logic            csn = 1'b1;
  logic            sdi = 1'b0;
  logic [1:0][7:0] wiper_code;
  logic [1:0]      load_stb;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  logic [7:0] model [2];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_wiper_serial_if i_dual_wiper_serial_if (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdi(sdi),
    .wiper_code(wiper_code), .load_stb(load_stb)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops one expected {channel,code} per strobe (R7, R2)
  always @(negedge clk) begin
    if (rst_n && load_stb != 2'b00) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected strobe", int'(load_stb), 0);
      end else begin
        int item, ch;
        item = exp_q.pop_front();
        ch = item >> 8;
        check("R7 strobe channel", int'(load_stb), 1 << ch);
        check("R2 code on strobe", int'(wiper_code[ch]), item & 255);
      end
    end
  end

  task automatic sclk_pulse(input logic b);
    @(negedge clk); sdi = b;
    repeat (HALF_SCLK) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF_SCLK) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic check_regs(input string req);
    check({req, " channel 0"}, int'(wiper_code[0]), int'(model[0]));
    check({req, " channel 1"}, int'(wiper_code[1]), int'(model[1]));
  endtask

  // Driver: sends n bits of val, MSB first, and predicts the result
  task automatic send_frame(input int n, input logic [15:0] val, input string req);
    @(negedge clk); csn = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) sclk_pulse(val[i]);
    repeat (6) @(negedge clk);
    check({req, " R3 no update before select rise"}, int'(wiper_code[0]) | (int'(wiper_code[1]) << 8),
          int'(model[0]) | (int'(model[1]) << 8));
    if (n >= 9) begin
      exp_q.push_back(int'(val[8:0]));
      model[val[8]] = val[7:0];
    end
    csn = 1'b1;
    repeat (12) @(negedge clk);
    check_regs(req);
  endtask

  initial begin
    model[0] = 8'd128;
    model[1] = 8'd128;
    repeat (3) @(negedge clk);
    check("R1 strobe at reset", int'(load_stb), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_regs("R1 midscale");
    check("R1 strobe idle", int'(load_stb), 0);

    send_frame(9, 16'h0A5, "R2 ch0");
    send_frame(9, 16'h13C, "R6 ch1 leaves ch0");
    send_frame(9, 16'h000, "R9 code 0");
    send_frame(9, 16'h1FF, "R9 code 255");
    send_frame(12, 16'hE05A, "R4 extra bits");
    send_frame(5, 16'h01F, "R5 short frame");
    send_frame(8, 16'h0FF, "R5 eight bits");
    // R8: clocks with select high, then a short frame that must stay ignored
    for (int k = 0; k < 6; k++) sclk_pulse(1'b1);
    send_frame(4, 16'h00F, "R8 idle clocks");
    send_frame(9, 16'h1C3, "R8 frame after idle clocks");
    send_frame(16, 16'hFF81, "R4 long frame");

    check("R7 all strobes seen", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule